// File: doc/BRIEF.md
# Persistent Calibration Code Register with Two-Wire Slave Access

This block keeps a single 7-bit calibration code that selects one of 128 steps of a current-output converter. The code is reached over a two-wire serial bus (I2C) on which the block is a slave at a fixed address. A master may write a new code or read the active one back. A written code drives the output at once. After the master ends the transaction, the code is copied into a modelled nonvolatile cell by a timed commit.

Reset stands for a power cycle. On reset the output code is taken from the nonvolatile cell, so the last committed value comes back without any bus traffic. A write-enable input must be high for a write to be taken. While a commit is running, the block refuses its address. Both bus lines pass through a synchronizer and a stability filter, so short spikes are rejected.

Top module: `vcom_cal_top`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1001111 (write frame 0x9E, read frame 0x9F). Any other address is not acknowledged and leaves the code unchanged.
- R2: In a write, the block acknowledges the data byte and sets `code_o` to bits 6..0 of that byte. Bit 7 is ignored. The output is already updated when the data byte's acknowledge clock ends.
- R3: In a read, the block sends one byte: a 0 bit, then the active code with the most significant bit first. After a master NACK, SDA is released and stays released until the next START or STOP.
- R4: When `wp_i` is low, the data byte of a write is not acknowledged, `code_o` does not change and no commit starts. The address byte is still acknowledged.
- R5: A STOP that ends an accepted write starts a commit of `COMMIT_CYC` clock cycles. When it completes, the nonvolatile cell holds the code, and a later reset brings `code_o` back to that value.
- R6: While a commit is running, the block does not acknowledge its address, and `code_o` is not changed by the bus.
- R7: A reset that arrives before a commit completes leaves the nonvolatile cell as it was. `code_o` then returns to the previously committed value.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clock cycles has no effect on the protocol.
- R9: Out of a first reset, `code_o` equals `NV_INIT` (default 0x40) and `sda_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, modelling power-up |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Write enable, active high; low means protected |
| sda_oe_o | output | 1 | Pulls SDA low while high (open-drain drive) |
| code_o | output | 7 | Active calibration code for the converter |

## Verification
Two things can fall in the same window: a commit that has just started at a STOP, and a new transaction from the master. The bench provokes this by issuing a START and an address straight after the STOP of a write, well inside the commit time. A missing acknowledge and an unchanged code show that the block refused the address. The same case is then run again with a reset instead of the new transaction. Here the result is judged by whether the reset output equals the older committed value.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
    localparam logic [6:0] DEV_ADDR = 7'b1001111;
    localparam int unsigned CODE_W  = 7;
    localparam int unsigned BYTE_W  = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_RNEXT
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] frame);
        return frame[BYTE_W-1:1] == DEV_ADDR;
    endfunction
endpackage

// File: rtl/vcal_line_filter.sv
module vcal_line_filter #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                clean_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign clean_o = clean_q;

    // R8: the filtered level only moves toward what the synchronizer presented
    assert_filter_follows_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean_q) |-> (clean_q == $past(sync_q[1])));
endmodule

// File: rtl/vcal_commit.sv
module vcal_commit #(
    parameter int unsigned    COMMIT_CYC = 5000,
    parameter logic [6:0]     NV_INIT    = 7'h40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic [6:0] code_i,
    output logic       busy_o,
    output logic [6:0] nv_o
);
    localparam int unsigned TW = $clog2(COMMIT_CYC + 1);

    logic [TW-1:0] tmr_q;
    logic          busy_q;
    logic [6:0]    lat_q;
    logic          done;
    logic [6:0]    nv_q = NV_INIT;

    assign done = busy_q && (tmr_q == TW'(COMMIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            lat_q  <= '0;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
                tmr_q  <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end else if (req_i) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
            lat_q  <= code_i;
        end
    end

    // Nonvolatile cell: not cleared by reset
    always_ff @(posedge clk) begin
        if (!rst && done) begin
            nv_q <= lat_q;
        end
    end

    assign busy_o = busy_q;
    assign nv_o   = nv_q;

    // R5: a commit starts only on a request
    assert_commit_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(req_i));
    // R7: the cell changes only at the completion of a commit
    assert_nv_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv_q) |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/vcal_slave.sv
module vcal_slave
    import vcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       wp_i,
    input  logic       busy_i,
    input  logic [6:0] nv_i,
    output logic       sda_oe_o,
    output logic       commit_o,
    output logic [6:0] code_o
);
    logic          scl_d, sda_d;
    bus_ev_t       ev;
    slv_state_e    st_q;
    logic [3:0]    bcnt_q;
    logic [7:0]    shr_q;
    logic [7:0]    tx_q;
    logic          rw_q, oe_q, pend_q, commit_q;
    logic [1:0]    wp_s;
    logic [6:0]    code_q;

    always_comb begin
        ev.start = scl_f && scl_d && sda_d && !sda_f;
        ev.stop  = scl_f && scl_d && !sda_d && sda_f;
        ev.rise  = scl_f && !scl_d;
        ev.fall  = !scl_f && scl_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            wp_s     <= 2'b00;
            st_q     <= S_IDLE;
            bcnt_q   <= '0;
            shr_q    <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            oe_q     <= 1'b0;
            pend_q   <= 1'b0;
            commit_q <= 1'b0;
            code_q   <= nv_i;
        end else begin
            scl_d    <= scl_f;
            sda_d    <= sda_f;
            wp_s     <= {wp_s[0], wp_i};
            commit_q <= 1'b0;
            if (ev.start) begin
                st_q   <= S_ADDR;
                bcnt_q <= '0;
                oe_q   <= 1'b0;
            end else if (ev.stop) begin
                st_q   <= S_IDLE;
                oe_q   <= 1'b0;
                pend_q <= 1'b0;
                commit_q <= pend_q;
            end else begin
                unique case (st_q)
                    S_ADDR, S_WDATA: begin
                        if (ev.rise) begin
                            shr_q  <= {shr_q[6:0], sda_f};
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (ev.fall && bcnt_q == 4'd8) begin
                            if (st_q == S_ADDR) begin
                                if (addr_hit(shr_q) && !busy_i) begin
                                    oe_q <= 1'b1;
                                    rw_q <= shr_q[0];
                                    st_q <= S_AACK;
                                end else begin
                                    st_q <= S_IDLE;
                                end
                            end else begin
                                st_q <= S_WACK;
                                if (wp_s[1] == 1'b1) begin
                                    oe_q   <= 1'b1;
                                    code_q <= shr_q[6:0];
                                    pend_q <= 1'b1;
                                end
                            end
                        end
                    end
                    S_AACK: if (ev.fall) begin
                        bcnt_q <= '0;
                        if (rw_q) begin
                            tx_q <= {1'b0, code_q};
                            oe_q <= 1'b1;
                            st_q <= S_RDATA;
                        end else begin
                            oe_q <= 1'b0;
                            st_q <= S_WDATA;
                        end
                    end
                    S_WACK: if (ev.fall) begin
                        oe_q <= 1'b0;
                        st_q <= S_IDLE;
                    end
                    S_RDATA: begin
                        if (ev.rise) begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end else if (ev.fall) begin
                            if (bcnt_q == 4'd8) begin
                                oe_q <= 1'b0;
                                st_q <= S_RACK;
                            end else begin
                                tx_q <= {tx_q[6:0], 1'b0};
                                oe_q <= !tx_q[6];
                            end
                        end
                    end
                    S_RACK: if (ev.rise) begin
                        st_q <= sda_f ? S_IDLE : S_RNEXT;
                    end
                    S_RNEXT: if (ev.fall) begin
                        bcnt_q <= '0;
                        tx_q   <= {1'b0, code_q};
                        oe_q   <= 1'b1;
                        st_q   <= S_RDATA;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign commit_o = commit_q;
    assign code_o   = code_q;

    // R3: the slave starts driving SDA only while SCL is low
    assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> !scl_f);
    // R6: no acknowledge of the address while a commit runs
    assert_busy_nack_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_ADDR && ev.fall && bcnt_q == 4'd8 && busy_i) |=> !oe_q);
    // R4: the code moves only with write permission present
    assert_code_needs_wp_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> $past(wp_s[1]));
    // R5: a commit request follows a STOP
    assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> ($past(st_q) != S_ADDR || $past(bcnt_q) == 4'd0) && $past(pend_q));
endmodule

// File: rtl/vcom_cal_top.sv
module vcom_cal_top #(
    parameter int unsigned FILT_CYC   = 4,
    parameter int unsigned COMMIT_CYC = 5000,
    parameter logic [6:0]  NV_INIT    = 7'h40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    output logic       sda_oe_o,
    output logic [6:0] code_o
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw, clean;
    logic              busy, commit;
    logic [6:0]        nv;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_filt
        vcal_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw[i]),
            .clean_o (clean[i])
        );
    end

    vcal_slave u_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (clean[0]),
        .sda_f    (clean[1]),
        .wp_i     (wp_i),
        .busy_i   (busy),
        .nv_i     (nv),
        .sda_oe_o (sda_oe_o),
        .commit_o (commit),
        .code_o   (code_o)
    );

    vcal_commit #(.COMMIT_CYC(COMMIT_CYC), .NV_INIT(NV_INIT)) u_commit (
        .clk    (clk),
        .rst    (rst),
        .req_i  (commit),
        .code_i (code_o),
        .busy_o (busy),
        .nv_o   (nv)
    );
endmodule

// File: tb/tb_vcom_cal_top.sv
module tb_vcom_cal_top;
    localparam int CLK_PERIOD = 10;
    localparam int COMMIT     = 2000;
    localparam int Q          = 12;
    localparam int H          = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1, wp = 1'b1;
    logic       sda_oe;
    logic [6:0] code;
    logic       sda_line;
    int         checks = 0, errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    vcom_cal_top #(.FILT_CYC(4), .COMMIT_CYC(COMMIT), .NV_INIT(7'h40)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
        .sda_oe_o(sda_oe), .code_o(code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        scl_m = 1'b1; sda_m = 1'b1;
        rst = 1'b1; tick(3);
        rst = 1'b0; tick(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            if (glitch && i == 4) begin
                scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q);
            end
            scl_m = 1'b1;
            if (glitch && i == 2) begin
                tick(H/2 - 1); sda_m = ~b[i]; tick(2); sda_m = b[i]; tick(H - H/2 - 1);
            end else begin
                tick(H);
            end
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H/2);
        ack = ~sda_line;
        tick(H - H/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(H/2);
            b = {b[6:0], sda_line};
            tick(H - H/2);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic write_code(input logic [7:0] d, input bit glitch, output bit a_ack, output bit d_ack);
        bus_start();
        send_byte(8'h9E, 1'b0, a_ack);
        send_byte(d, glitch, d_ack);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(code == 7'h40, "R9 code after reset", code, 7'h40);
        chk(sda_oe == 1'b0, "R9 sda released after reset", sda_oe, 0);
    endtask

    task automatic t_read(input logic [6:0] exp);
        bit a; logic [7:0] b;
        bus_start();
        send_byte(8'h9F, 1'b0, a);
        chk(a, "R1 read address acked", a, 1);
        recv_byte(1'b0, b);
        chk(b == {1'b0, exp}, "R3 read byte", b, {1'b0, exp});
        tick(H);
        chk(sda_oe == 1'b0, "R3 sda released after master nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_write_commit();
        bit a, d;
        write_code(8'hA5, 1'b0, a, d);
        chk(a && d, "R1 R2 write acks", {a, d}, 2'b11);
        chk(code == 7'h25, "R2 code updated, bit 7 dropped", code, 7'h25);
        bus_stop();
        bus_start();
        send_byte(8'h9E, 1'b0, a);
        chk(!a, "R6 address refused during commit", a, 0);
        bus_stop();
        chk(code == 7'h25, "R6 code held during commit", code, 7'h25);
        tick(COMMIT + 200);
        do_reset();
        chk(code == 7'h25, "R5 committed code restored by reset", code, 7'h25);
    endtask

    task automatic t_wrong_addr();
        bit a;
        bus_start();
        send_byte(8'hA0, 1'b0, a);
        chk(!a, "R1 foreign address not acked", a, 0);
        send_byte(8'h11, 1'b0, a);
        bus_stop();
        chk(code == 7'h25, "R1 foreign write leaves code", code, 7'h25);
    endtask

    task automatic t_protected();
        bit a, d;
        wp = 1'b0; tick(4);
        write_code(8'h11, 1'b0, a, d);
        chk(a, "R4 address acked while protected", a, 1);
        chk(!d, "R4 data refused while protected", d, 0);
        chk(code == 7'h25, "R4 code unchanged while protected", code, 7'h25);
        bus_stop();
        bus_start();
        send_byte(8'h9E, 1'b0, a);
        chk(a, "R4 no commit started when protected", a, 1);
        bus_stop();
        wp = 1'b1; tick(4);
    endtask

    task automatic t_abort();
        bit a, d;
        write_code(8'h33, 1'b0, a, d);
        chk(code == 7'h33, "R2 code before abort", code, 7'h33);
        bus_stop();
        tick(50);
        do_reset();
        chk(code == 7'h25, "R7 reset mid-commit restores old code", code, 7'h25);
    endtask

    task automatic t_glitch();
        bit a, d;
        write_code(8'h0A, 1'b1, a, d);
        chk(a && d, "R8 acks with glitches", {a, d}, 2'b11);
        chk(code == 7'h0A, "R8 glitches rejected", code, 7'h0A);
        bus_stop();
        tick(COMMIT + 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_read(7'h40);
        t_write_commit();
        t_wrong_addr();
        t_protected();
        t_abort();
        t_glitch();
        t_read(7'h0A);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule